// File: doc/BRIEF.md
# Block Cipher Chaining-Mode Controller

This block sits between a 32-bit data stream and a 128-bit block-cipher engine and applies one of four chaining modes to each block: codebook, cipher-block chaining, output feedback and cipher feedback. Each mode works in both the encrypt and the decrypt direction. A 128-bit starting vector is loaded as four 32-bit words and seeds a 128-bit chaining register. All feedback modes chain whole 128-bit blocks.

Data arrives as four 32-bit beats per block. The controller then builds the cipher input from the gathered block and the chaining register. It starts the engine through a one-cycle start pulse and waits for the engine's done strobe. It then forms the result from the engine output, the chaining register and the gathered data, updates the chaining register, and returns the result as four 32-bit beats. The engine is external and is reached through a start/done port. It may take any number of cycles. Mode and direction are chosen once per block.

Top module: `blkmode_ctrl`

## Requirements
- R1: With cfg_mode 2'b00 (codebook), the engine input is the gathered block, cph_decrypt equals the latched direction, the output is the engine result, and the chaining register is neither used nor changed.
- R2: With cfg_mode 2'b01 and cfg_decrypt 0, the engine encrypts data XOR chain, the output is the engine result, and the chain then holds that output.
- R3: With cfg_mode 2'b01 and cfg_decrypt 1, the engine decrypts the gathered block, the output is the engine result XOR chain, and the chain then holds the gathered (received) block.
- R4: With cfg_mode 2'b10 (output feedback), the engine encrypts the chain, the output is data XOR engine result, and the full 128-bit engine result replaces the chain, in either direction.
- R5: With cfg_mode 2'b11 (cipher feedback), the engine encrypts the chain and the output is data XOR engine result. The chain then holds that output when encrypting, or the gathered block when decrypting.
- R6: In modes 2'b10 and 2'b11, cph_decrypt is 0 at every start pulse, whatever cfg_decrypt says.
- R7: Four iv_valid words (first word = bits 127:96) replace the chaining register. They are taken only while the controller is idle with no data beat pending, and an iv_valid word wins over an in_valid word in the same cycle.
- R8: A block is four accepted in_word beats, the first being bits 127:96. The result leaves as exactly four consecutive out_valid cycles in the same word order.
- R9: One cycle after the fourth input beat, cph_start pulses high for exactly one cycle. cph_block stays stable from that pulse until cph_done.
- R10: in_ready is low from the fourth input beat until the last output beat has been shown. in_valid and iv_valid words offered in that time are ignored.
- R11: After reset, out_valid and cph_start are 0, in_ready is 1, and the chaining register is all zeros.
- R12: cfg_mode and cfg_decrypt are sampled with the first beat of a block. Changes during the remaining beats have no effect on that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Chaining mode: 00 codebook, 01 block chaining, 10 output feedback, 11 cipher feedback |
| cfg_decrypt | input | 1 | 1 selects the decrypt direction |
| iv_valid | input | 1 | Starting-vector word strobe |
| iv_word | input | WORD_W | Starting-vector word |
| in_valid | input | 1 | Data word strobe |
| in_word | input | WORD_W | Data word |
| in_ready | output | 1 | Controller accepts data words |
| out_valid | output | 1 | Result word valid |
| out_word | output | WORD_W | Result word |
| cph_start | output | 1 | One-cycle engine start |
| cph_decrypt | output | 1 | Engine direction, 1 = decrypt |
| cph_block | output | BLOCK_W | Engine input block |
| cph_done | input | 1 | Engine result strobe |
| cph_result | input | BLOCK_W | Engine result block |

## Verification
The bench drives each mode in both directions against a simple invertible stand-in engine. It confirms round trips: two chained encrypted blocks decrypt back to the original plaintext only if the chain holds ciphertext on both sides. A design that fed back plaintext in block chaining, or only part of the engine result in output feedback, would lose the second block. In the feedback-mode decrypts it records the engine direction at each start. A controller that passed cfg_decrypt through to the engine there would yield garbage. It also scrambles the mode inputs after the first beat, offers data and vector words while the block is busy, and reloads the vector between sessions. A controller that latched late, accepted words while busy, or kept stale chain state would miscompare.

// File: rtl/blkmode_pkg.sv
package blkmode_pkg;

   typedef enum logic [1:0] {
      MODE_ECB = 2'b00,
      MODE_CBC = 2'b01,
      MODE_OFB = 2'b10,
      MODE_CFB = 2'b11
   } chain_mode_e;

   typedef enum logic [1:0] {
      ST_GATHER = 2'b00,
      ST_LAUNCH = 2'b01,
      ST_WAIT   = 2'b10,
      ST_EMIT   = 2'b11
   } ctl_state_e;

endpackage

// File: rtl/blk_shift_in.sv
// Gathers BEATS words into one block, first word ending up most significant.
module blk_shift_in #(
   parameter int WORD_W = 32,
   parameter int BEATS  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      push,
   input  logic [WORD_W-1:0]         word,
   output logic [WORD_W*BEATS-1:0]   block,
   output logic                      empty,
   output logic                      last
);
   localparam int BLOCK_W = WORD_W * BEATS;
   localparam int CW      = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam logic [CW-1:0] TOP_IDX = CW'(BEATS - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         block <= '0;
      end else if (push) begin
         cnt_q <= (cnt_q == TOP_IDX) ? '0 : cnt_q + 1'b1;
         block <= {block[BLOCK_W-WORD_W-1:0], word};
      end
   end

   assign empty = (cnt_q == '0);
   assign last  = push && (cnt_q == TOP_IDX);
endmodule

// File: rtl/blk_shift_out.sv
// Streams one block out as BEATS consecutive words, most significant first.
module blk_shift_out #(
   parameter int WORD_W = 32,
   parameter int BEATS  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic [WORD_W*BEATS-1:0]   block,
   output logic [WORD_W-1:0]         word,
   output logic                      valid,
   output logic                      last
);
   localparam int BLOCK_W = WORD_W * BEATS;
   localparam int CW      = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam logic [CW-1:0] TOP_IDX = CW'(BEATS - 1);

   logic [BLOCK_W-1:0] sh_q;
   logic [CW-1:0]      cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
         valid <= 1'b0;
      end else if (load) begin
         sh_q  <= block;
         cnt_q <= '0;
         valid <= 1'b1;
      end else if (valid) begin
         sh_q <= {sh_q[BLOCK_W-WORD_W-1:0], {WORD_W{1'b0}}};
         if (cnt_q == TOP_IDX) begin
            valid <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign word = sh_q[BLOCK_W-1 -: WORD_W];
   assign last = valid && (cnt_q == TOP_IDX);
endmodule

// File: rtl/blk_mode_xform.sv
// Per-mode forming of engine input, result block and next chaining value.
module blk_mode_xform
   import blkmode_pkg::*;
#(
   parameter int BLOCK_W = 128
) (
   input  chain_mode_e         mode,
   input  logic                decrypt,
   input  logic [BLOCK_W-1:0]  data,
   input  logic [BLOCK_W-1:0]  chain,
   input  logic [BLOCK_W-1:0]  result,
   output logic [BLOCK_W-1:0]  eng_in,
   output logic                eng_dec,
   output logic [BLOCK_W-1:0]  out_blk,
   output logic [BLOCK_W-1:0]  chain_nxt
);
   always_comb begin
      eng_in    = data;
      eng_dec   = 1'b0;
      out_blk   = result;
      chain_nxt = chain;
      unique case (mode)
         MODE_ECB: begin
            eng_in  = data;
            eng_dec = decrypt;
            out_blk = result;
         end
         MODE_CBC: begin
            if (decrypt) begin
               eng_in    = data;
               eng_dec   = 1'b1;
               out_blk   = result ^ chain;
               chain_nxt = data;
            end else begin
               eng_in    = data ^ chain;
               out_blk   = result;
               chain_nxt = result;
            end
         end
         MODE_OFB: begin
            eng_in    = chain;
            out_blk   = data ^ result;
            chain_nxt = result;
         end
         MODE_CFB: begin
            eng_in    = chain;
            out_blk   = data ^ result;
            chain_nxt = decrypt ? data : (data ^ result);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/blkmode_ctrl.sv
module blkmode_ctrl
   import blkmode_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int BLOCK_W = 128
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         cfg_mode,
   input  logic               cfg_decrypt,
   input  logic               iv_valid,
   input  logic [WORD_W-1:0]  iv_word,
   input  logic               in_valid,
   input  logic [WORD_W-1:0]  in_word,
   output logic               in_ready,
   output logic               out_valid,
   output logic [WORD_W-1:0]  out_word,
   output logic               cph_start,
   output logic               cph_decrypt,
   output logic [BLOCK_W-1:0] cph_block,
   input  logic               cph_done,
   input  logic [BLOCK_W-1:0] cph_result
);
   localparam int BEATS = BLOCK_W / WORD_W;

   generate
      if ((BLOCK_W % WORD_W) != 0 || BEATS < 2) begin : g_bad_geometry
         $error("blkmode_ctrl: BLOCK_W must be a multiple of WORD_W, at least two words");
      end
   endgenerate

   ctl_state_e         st_q;
   chain_mode_e        mode_q;
   logic               dec_q;
   logic [BLOCK_W-1:0] chain_q;
   logic               iv_fill_q;

   logic               iv_acc, dat_acc;
   logic               iv_empty, iv_last, dat_empty, dat_last;
   logic [BLOCK_W-1:0] iv_blk, dat_blk;
   logic [BLOCK_W-1:0] out_blk, chain_nxt;
   logic               out_last;
   logic               wait_st;
   logic               finish_blk;

   assign iv_acc     = iv_valid && (st_q == ST_GATHER) && dat_empty;
   assign in_ready   = (st_q == ST_GATHER) && iv_empty && !iv_fill_q;
   assign dat_acc    = in_valid && in_ready && !iv_acc;
   assign wait_st    = (st_q == ST_WAIT);
   assign finish_blk = wait_st && cph_done;
   assign cph_start  = (st_q == ST_LAUNCH);

   blk_shift_in #(.WORD_W(WORD_W), .BEATS(BEATS)) u_iv_in (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (iv_acc),
      .word  (iv_word),
      .block (iv_blk),
      .empty (iv_empty),
      .last  (iv_last)
   );

   blk_shift_in #(.WORD_W(WORD_W), .BEATS(BEATS)) u_dat_in (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (dat_acc),
      .word  (in_word),
      .block (dat_blk),
      .empty (dat_empty),
      .last  (dat_last)
   );

   blk_mode_xform #(.BLOCK_W(BLOCK_W)) u_xform (
      .mode      (mode_q),
      .decrypt   (dec_q),
      .data      (dat_blk),
      .chain     (chain_q),
      .result    (cph_result),
      .eng_in    (cph_block),
      .eng_dec   (cph_decrypt),
      .out_blk   (out_blk),
      .chain_nxt (chain_nxt)
   );

   blk_shift_out #(.WORD_W(WORD_W), .BEATS(BEATS)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (finish_blk),
      .block (out_blk),
      .word  (out_word),
      .valid (out_valid),
      .last  (out_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_GATHER;
      end else begin
         unique case (st_q)
            ST_GATHER: if (dat_last)   st_q <= ST_LAUNCH;
            ST_LAUNCH:                 st_q <= ST_WAIT;
            ST_WAIT:   if (cph_done)   st_q <= ST_EMIT;
            ST_EMIT:   if (out_last)   st_q <= ST_GATHER;
            default:                   st_q <= ST_GATHER;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_ECB;
         dec_q  <= 1'b0;
      end else if (dat_acc && dat_empty) begin
         mode_q <= chain_mode_e'(cfg_mode);
         dec_q  <= cfg_decrypt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iv_fill_q <= 1'b0;
         chain_q   <= '0;
      end else begin
         iv_fill_q <= iv_last;
         if (iv_fill_q)
            chain_q <= iv_blk;
         else if (finish_blk)
            chain_q <= chain_nxt;
      end
   end
endmodule

// File: rtl/blkmode_ctrl_chk.sv
module blkmode_ctrl_chk #(
   parameter int BEATS   = 4,
   parameter int BLOCK_W = 128
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_ready,
   input logic               out_valid,
   input logic               cph_start,
   input logic               cph_decrypt,
   input logic [BLOCK_W-1:0] cph_block,
   input logic               cph_done,
   input logic [1:0]         mode_q,
   input logic               wait_st
);
   logic [7:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         run_q <= '0;
      else if (out_valid) run_q <= run_q + 8'd1;
      else                run_q <= '0;
   end

   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cph_start |=> !cph_start); // R9

   AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_st && !cph_done) |=> $stable(cph_block)); // R9

   AST_STREAM_ENCRYPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cph_start && mode_q[1]) |-> !cph_decrypt); // R6

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid || cph_start || wait_st) |-> !in_ready); // R10

   AST_BURST_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && run_q == 8'(BEATS - 1)) |=> !out_valid); // R8

   AST_BURST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> ($past(run_q) == 8'(BEATS - 1))); // R8
endmodule

bind blkmode_ctrl blkmode_ctrl_chk #(.BEATS(BEATS), .BLOCK_W(BLOCK_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_ready    (in_ready),
   .out_valid   (out_valid),
   .cph_start   (cph_start),
   .cph_decrypt (cph_decrypt),
   .cph_block   (cph_block),
   .cph_done    (cph_done),
   .mode_q      (mode_q),
   .wait_st     (wait_st)
);

// File: tb/blkmode_ctrl_test.sv
module blkmode_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [127:0] KEY = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   cfg_mode = 2'b00;
   logic         cfg_decrypt = 1'b0;
   logic         iv_valid = 1'b0;
   logic [31:0]  iv_word = '0;
   logic         in_valid = 1'b0;
   logic [31:0]  in_word = '0;
   logic         in_ready, out_valid, cph_start, cph_decrypt;
   logic [31:0]  out_word;
   logic [127:0] cph_block;
   logic         cph_done = 1'b0;
   logic [127:0] cph_result = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;
   logic [127:0] ref_chain = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   blkmode_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_decrypt(cfg_decrypt),
      .iv_valid(iv_valid), .iv_word(iv_word), .in_valid(in_valid), .in_word(in_word),
      .in_ready(in_ready), .out_valid(out_valid), .out_word(out_word),
      .cph_start(cph_start), .cph_decrypt(cph_decrypt), .cph_block(cph_block),
      .cph_done(cph_done), .cph_result(cph_result)
   );

   function automatic logic [127:0] fwd(logic [127:0] x);
      return {x[119:0], x[127:120]} ^ KEY;
   endfunction

   function automatic logic [127:0] inv(logic [127:0] y);
      logic [127:0] t;
      t = y ^ KEY;
      return {t[7:0], t[127:8]};
   endfunction

   // stand-in engine: three-cycle latency, one-cycle done strobe
   logic [127:0] m_blk = '0;
   logic         m_dir = 1'b0;
   logic         m_busy = 1'b0;
   int           m_cnt = 0;
   int           n_starts = 0;

   always @(posedge clk) begin
      cph_done <= 1'b0;
      if (cph_start) begin
         m_busy   <= 1'b1;
         m_cnt    <= 0;
         m_blk    <= cph_block;
         m_dir    <= cph_decrypt;
         n_starts <= n_starts + 1;
      end else if (m_busy) begin
         if (m_cnt == 2) begin
            m_busy     <= 1'b0;
            cph_done   <= 1'b1;
            cph_result <= m_dir ? inv(m_blk) : fwd(m_blk);
         end else begin
            m_cnt <= m_cnt + 1;
         end
      end
   end

   task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic load_iv(logic [127:0] iv);
      for (int b = 0; b < 4; b++) begin
         iv_valid = 1'b1;
         iv_word  = iv[127-32*b -: 32];
         @(negedge clk);
      end
      iv_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      ref_chain = iv;
   endtask

   // one block through the controller, checked against the requirement model
   task automatic run_block(logic [1:0] mode, bit dec, logic [127:0] data,
                            string tag, output logic [127:0] got);
      logic [127:0] e_in, e_out, y;
      bit e_dir;
      int s0, beats, guard;
      s0 = n_starts;
      e_dir = 1'b0;
      case (mode)
         2'b00: begin e_in = data; e_dir = dec; e_out = dec ? inv(data) : fwd(data); end
         2'b01: begin
            if (dec) begin e_in = data; e_dir = 1'b1; e_out = inv(data) ^ ref_chain; ref_chain = data; end
            else begin e_in = data ^ ref_chain; e_out = fwd(e_in); ref_chain = e_out; end
         end
         2'b10: begin e_in = ref_chain; y = fwd(ref_chain); e_out = data ^ y; ref_chain = y; end
         default: begin e_in = ref_chain; y = fwd(ref_chain); e_out = data ^ y;
                        ref_chain = dec ? data : e_out; end
      endcase
      for (int b = 0; b < 4; b++) begin
         in_valid = 1'b1;
         in_word  = data[127-32*b -: 32];
         // R12: configuration scrambled after the first beat
         cfg_mode    = (b == 0) ? mode : ~mode;
         cfg_decrypt = (b == 0) ? dec : ~dec;
         @(negedge clk);
      end
      // R10: words offered while busy must be ignored
      in_word = 32'hdead_beef; iv_word = 32'h5555_aaaa; iv_valid = 1'b1;
      @(negedge clk);
      chk("R10 in_ready low while busy", {127'd0, in_ready}, 128'd0);
      @(negedge clk);
      in_valid = 1'b0; iv_valid = 1'b0;
      guard = 0;
      while (!out_valid && guard < 50) begin @(negedge clk); guard++; end
      got = '0;
      beats = 0;
      while (out_valid && beats < 8) begin
         got = {got[95:0], out_word};
         beats++;
         @(negedge clk);
      end
      chk({tag, " result"}, got, e_out);
      chk("R8 four result beats", 128'(beats), 128'd4);
      chk("R9 one start per block", 128'(n_starts - s0), 128'd1);
      chk({tag, " engine input"}, m_blk, e_in);
      chk({tag, " engine direction"}, {127'd0, m_dir}, {127'd0, e_dir});
      @(negedge clk);
   endtask

   task automatic test_reset();
      chk("R11 out_valid after reset", {127'd0, out_valid}, 128'd0);
      chk("R11 cph_start after reset", {127'd0, cph_start}, 128'd0);
      chk("R11 in_ready after reset", {127'd0, in_ready}, 128'd1);
   endtask

   task automatic test_zero_chain();
      logic [127:0] r;
      // R11: chain is zero, so output feedback yields data ^ fwd(0)
      run_block(2'b10, 1'b0, 128'h11112222_33334444_55556666_77778888, "R11 R4", r);
      chk("R11 zero chain", r, 128'h11112222_33334444_55556666_77778888 ^ fwd('0));
   endtask

   task automatic test_ecb();
      logic [127:0] a, b, p;
      p = 128'h00112233_44556677_8899aabb_ccddeeff;
      run_block(2'b00, 1'b0, p, "R1 enc", a);
      load_iv(128'hffff0000_ffff0000_ffff0000_ffff0000);
      run_block(2'b00, 1'b0, p, "R1 enc after IV", b);
      chk("R1 chain ignored", b, a);
      run_block(2'b00, 1'b1, a, "R1 dec", b);
      chk("R1 round trip", b, p);
   endtask

   task automatic test_cbc();
      logic [127:0] iv, p1, p2, c1, c2, r;
      iv = 128'h01020304_05060708_090a0b0c_0d0e0f10;
      p1 = 128'hcafef00d_00000000_12345678_9abcdef0;
      p2 = p1;
      load_iv(iv);
      run_block(2'b01, 1'b0, p1, "R2 block1", c1);
      run_block(2'b01, 1'b0, p2, "R2 block2", c2);
      chk("R2 equal plaintext differs", {127'd0, c1 == c2}, 128'd0);
      load_iv(iv);
      run_block(2'b01, 1'b0, p1, "R7 reload restarts chain", r);
      chk("R7 reload", r, c1);
      load_iv(iv);
      run_block(2'b01, 1'b1, c1, "R3 block1", r);
      chk("R3 plain1", r, p1);
      run_block(2'b01, 1'b1, c2, "R3 block2", r);
      chk("R3 plain2", r, p2);
   endtask

   task automatic test_ofb();
      logic [127:0] iv, p1, p2, c1, c2, r;
      iv = 128'h89abcdef_01234567_fedcba98_76543210;
      p1 = 128'h31415926_53589793_23846264_33832795;
      p2 = 128'h27182818_28459045_23536028_74713526;
      load_iv(iv);
      run_block(2'b10, 1'b0, p1, "R4 block1", c1);
      run_block(2'b10, 1'b0, p2, "R4 block2", c2);
      chk("R4 second keystream", c2, p2 ^ fwd(fwd(iv)));
      load_iv(iv);
      run_block(2'b10, 1'b1, c1, "R6 R4 dec1", r);
      chk("R4 plain1", r, p1);
      run_block(2'b10, 1'b1, c2, "R6 R4 dec2", r);
      chk("R4 plain2", r, p2);
   endtask

   task automatic test_cfb();
      logic [127:0] iv, p1, p2, c1, c2, r;
      iv = 128'h0badc0de_0badc0de_0badc0de_0badc0de;
      p1 = 128'h600dd00d_00000001_00000002_00000003;
      p2 = 128'hffffffff_eeeeeeee_dddddddd_cccccccc;
      load_iv(iv);
      run_block(2'b11, 1'b0, p1, "R5 block1", c1);
      run_block(2'b11, 1'b0, p2, "R5 block2", c2);
      chk("R5 ciphertext feedback", c2, p2 ^ fwd(c1));
      load_iv(iv);
      run_block(2'b11, 1'b1, c1, "R6 R5 dec1", r);
      chk("R5 plain1", r, p1);
      run_block(2'b11, 1'b1, c2, "R6 R5 dec2", r);
      chk("R5 plain2", r, p2);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_zero_chain();
      test_ecb();
      test_cbc();
      test_ofb();
      test_cfb();
      summary();
   end
endmodule